// File: doc/BRIEF.md
# Multilayer Copy Scan Test Decompressor

This block turns a compressed serial test stream, one bit per accepted transfer, into full-width slices for a bank of parallel scan chains. An internal fill buffer with one flip-flop per chain is viewed as a stack of layers. The top layer treats the whole buffer as one group, and every lower layer splits each group above it into equal, smaller groups. A control bit of 1 duplicates the group just completed into the next group of the same size in a single cycle. A control bit of 0 moves one layer down. A 0 at the lowest layer opens a short window in which raw data bits are shifted into the buffer one at a time.

Whenever the buffer holds a complete slice, the block raises the scan shift enable for one cycle so that each chain takes one bit. It does not clock the chains on any other cycle. The input side is a valid/ready stream. A transfer happens only on a cycle where both `in_valid` and `in_ready` are high. The block drops `in_ready` while it presents a slice, while it is idle and after the pattern finishes. A source that drops `in_valid` only delays decoding and loses no state. `start` begins a pattern of `chain_len` slices and `abort` abandons it. Both are plain level-sampled controls.

Top module: `mlc_decomp`

## Requirements
- R1: After reset `in_ready`, `scan_en`, `pattern_done` and `proto_err` are low and `slice_out` is all zeros.
- R2: A `start` clears the buffer to zeros, sets the fill position to 0 and the layer to the top layer, and raises `in_ready` on the next cycle.
- R3: A control 1 at layer l (group size g = NCHAIN >> (SPLIT_LOG2*l)) with fill position k > 0 copies buffer bits k-g..k-1 into bits k..k+g-1 and advances k by g.
- R4: A control 0 at any layer above the lowest moves down one layer and leaves the buffer unchanged.
- R5: A control 0 at the lowest layer makes the next GLAST accepted bits raw data. The first of them goes to `slice_out[k]`, the next to `slice_out[k+1]`, and so on.
- R6: After a copy or a raw group, the current layer becomes the lowest-index layer whose group size divides the new fill position k.
- R7: When k reaches NCHAIN, `scan_en` is high for exactly the next cycle and `slice_out` carries the completed slice. `in_ready` is low in that cycle. `scan_en` is never high otherwise.
- R8: A control 1 at the top layer with k = 0, after at least one slice of the pattern, presents the previous slice again unchanged.
- R9: A control 1 at the top layer before the first slice of a pattern, or at a lower layer with k = 0, raises `proto_err` for one cycle and changes neither the buffer, k nor the layer.
- R10: After `chain_len` slices, `pattern_done` goes high and stays high, and `in_ready` stays low, until the next `start`.
- R11: `abort` returns the block to idle with `in_ready` low, without presenting a slice and without raising `pattern_done`.
- R12: A bit is consumed only when `in_valid` and `in_ready` are both high. With `in_valid` low, the decode state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new pattern; clears buffer and counters |
| abort | input | 1 | Abandon the current pattern and go idle |
| chain_len | input | CNT_W | Number of slices in the pattern (scan chain length) |
| in_valid | input | 1 | Serial stream bit is valid |
| in_bit | input | 1 | Serial control or raw data bit |
| in_ready | output | 1 | Block accepts a bit this cycle |
| slice_out | output | NCHAIN | Buffer contents, one bit per scan chain |
| scan_en | output | 1 | Scan shift enable, one cycle per completed slice |
| pattern_done | output | 1 | All slices of the pattern have been presented |
| proto_err | output | 1 | One-cycle flag for a copy with no source group |

## Verification
The bench decodes a long pattern in which every 8-bit slice value occurs, with repeated slices mixed in. Each slice is encoded in the bench by a greedy copy-first encoder, so copies at every layer and raw groups at every position are all exercised. A wrong source offset or a wrong layer re-derivation after a copy would corrupt bits in the upper half or upper quarter of some slices. A missing top-layer reuse would hang the stream. The bench also checks both illegal-copy cases: a design that acted on them would write stale or shifted data into the buffer, and one that did not flag them would leave `proto_err` silent. It also checks idle gaps on `in_valid`, which a design consuming held bits would double-load, and the cut-off at `chain_len`, where an off-by-one shows up as an extra or missing `scan_en` pulse.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_CTRL = 2'd1,
    MS_RAW  = 2'd2,
    MS_SCAN = 2'd3
  } mlc_mode_e;

  // Group size of layer l when each layer splits by 2**split_log2.
  function automatic int unsigned grp_size(int unsigned n, int unsigned split_log2,
                                           int unsigned l);
    return n >> (split_log2 * l);
  endfunction

endpackage

// File: rtl/mlc_layer_pick.sv
// Picks the lowest-index layer whose group size divides the fill position.
module mlc_layer_pick #(
  parameter int unsigned NCHAIN     = 8,
  parameter int unsigned NLAYER     = 3,
  parameter int unsigned SPLIT_LOG2 = 1,
  parameter int unsigned KW         = 4,
  parameter int unsigned LW         = 2
) (
  input  logic [KW-1:0] fill,
  output logic [LW-1:0] layer
);
  import mlc_pkg::*;

  logic [NLAYER-1:0] fits;

  for (genvar l = 0; l < NLAYER; l++) begin : g_fit
    localparam int unsigned G = grp_size(NCHAIN, SPLIT_LOG2, l);
    assign fits[l] = ((fill % KW'(G)) == '0);
  end

  always_comb begin
    layer = LW'(NLAYER - 1);
    for (int l = NLAYER - 1; l >= 0; l--) begin
      if (fits[l]) layer = LW'(l);
    end
  end

endmodule

// File: rtl/mlc_buffer.sv
// Fill buffer: one flip-flop per chain, with a block-copy path per layer
// and a single-bit raw write path.
module mlc_buffer #(
  parameter int unsigned NCHAIN     = 8,
  parameter int unsigned NLAYER     = 3,
  parameter int unsigned SPLIT_LOG2 = 1,
  parameter int unsigned KW         = 4,
  parameter int unsigned LW         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              copy_we,
  input  logic [LW-1:0]     copy_layer,
  input  logic [KW-1:0]     pos,
  input  logic              shift_we,
  input  logic              shift_bit,
  output logic [NCHAIN-1:0] data
);
  import mlc_pkg::*;

  logic [NCHAIN-1:0] nxt;

  for (genvar i = 0; i < NCHAIN; i++) begin : g_bit
    logic [NLAYER-1:0] hit;
    logic [NLAYER-1:0] src;

    for (genvar l = 0; l < NLAYER; l++) begin : g_lay
      localparam int unsigned G    = grp_size(NCHAIN, SPLIT_LOG2, l);
      localparam int unsigned BASE = (i / G) * G;
      if (i >= G) begin : g_src
        // Bit i belongs to the destination group starting at BASE.
        assign hit[l] = copy_we && (copy_layer == LW'(l)) && (pos == KW'(BASE));
        assign src[l] = data[i - G];
      end else begin : g_nosrc
        assign hit[l] = 1'b0;
        assign src[l] = 1'b0;
      end
    end

    always_comb begin
      nxt[i] = data[i];
      if (shift_we && pos == KW'(i)) nxt[i] = shift_bit;
      for (int l = 0; l < NLAYER; l++) begin
        if (hit[l]) nxt[i] = src[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data <= '0;
    else if (clr) data <= '0;
    else          data <= nxt;
  end

  // A copy always has a completed source group below it.
  assert_copy_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    copy_we |-> (pos != '0));

  // Copy and raw write never share a cycle.
  assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(copy_we && shift_we));

endmodule

// File: rtl/mlc_ctrl.sv
// Decode sequencer: interprets control bits, counts fill and raw bits,
// tracks the layer and the slices of the pattern.
module mlc_ctrl #(
  parameter int unsigned NCHAIN     = 8,
  parameter int unsigned NLAYER     = 3,
  parameter int unsigned SPLIT_LOG2 = 1,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned KW         = 4,
  parameter int unsigned LW         = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] chain_len,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic [KW-1:0]    fill_nxt,
  input  logic [LW-1:0]    lay_pick,
  output logic             clr,
  output logic             copy_we,
  output logic [LW-1:0]    copy_layer,
  output logic [KW-1:0]    pos,
  output logic             shift_we,
  output logic             shift_bit,
  output logic             scan_en,
  output logic             pattern_done,
  output logic             proto_err
);
  import mlc_pkg::*;

  localparam int unsigned GLAST = grp_size(NCHAIN, SPLIT_LOG2, NLAYER - 1);
  localparam int unsigned RW    = (GLAST > 1) ? $clog2(GLAST) : 1;
  localparam int unsigned NTAB  = 1 << LW;
  localparam logic [LW-1:0] LAST = LW'(NLAYER - 1);
  localparam logic [KW-1:0] FULL = KW'(NCHAIN);

  mlc_mode_e        mode_q, mode_d;
  logic [KW-1:0]    k_q, k_d;
  logic [LW-1:0]    layer_q, layer_d;
  logic [RW-1:0]    raw_q, raw_d;
  logic [CNT_W-1:0] slices_q, slices_d;
  logic             prev_q, prev_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [KW-1:0]    gtab [NTAB];
  logic [KW-1:0]    g_cur;
  logic             accept;

  for (genvar l = 0; l < NTAB; l++) begin : g_tab
    localparam int unsigned LL = (l < NLAYER) ? l : NLAYER - 1;
    assign gtab[l] = KW'(grp_size(NCHAIN, SPLIT_LOG2, LL));
  end

  assign g_cur      = gtab[layer_q];
  assign in_ready   = (mode_q == MS_CTRL) || (mode_q == MS_RAW);
  assign accept     = in_valid && in_ready;
  assign copy_layer = layer_q;
  assign pos        = k_q;
  assign shift_bit  = in_bit;

  always_comb begin
    mode_d   = mode_q;
    k_d      = k_q;
    layer_d  = layer_q;
    raw_d    = raw_q;
    slices_d = slices_q;
    prev_d   = prev_q;
    done_d   = done_q;
    err_d    = 1'b0;
    fill_nxt = k_q;
    copy_we  = 1'b0;
    shift_we = 1'b0;
    clr      = 1'b0;

    unique case (mode_q)
      MS_CTRL: begin
        if (accept) begin
          if (in_bit) begin
            if (k_q == '0 && (layer_q != '0 || !prev_q)) begin
              err_d = 1'b1;
            end else begin
              if (k_q == '0) begin
                fill_nxt = FULL;
              end else begin
                copy_we  = 1'b1;
                fill_nxt = k_q + g_cur;
              end
              k_d = fill_nxt;
              if (fill_nxt == FULL) mode_d = MS_SCAN;
              else                  layer_d = lay_pick;
            end
          end else if (layer_q == LAST) begin
            mode_d = MS_RAW;
            raw_d  = '0;
          end else begin
            layer_d = layer_q + LW'(1);
          end
        end
      end
      MS_RAW: begin
        if (accept) begin
          shift_we = 1'b1;
          fill_nxt = k_q + KW'(1);
          k_d      = fill_nxt;
          raw_d    = raw_q + RW'(1);
          if (raw_q == RW'(GLAST - 1)) begin
            if (fill_nxt == FULL) begin
              mode_d = MS_SCAN;
            end else begin
              mode_d  = MS_CTRL;
              layer_d = lay_pick;
            end
          end
        end
      end
      MS_SCAN: begin
        k_d      = '0;
        layer_d  = '0;
        prev_d   = 1'b1;
        slices_d = slices_q + CNT_W'(1);
        if (slices_q + CNT_W'(1) == chain_len) begin
          done_d = 1'b1;
          mode_d = MS_IDLE;
        end else begin
          mode_d = MS_CTRL;
        end
      end
      default: ;
    endcase

    if (abort) begin
      mode_d   = MS_IDLE;
      copy_we  = 1'b0;
      shift_we = 1'b0;
      err_d    = 1'b0;
    end

    if (start) begin
      mode_d   = MS_CTRL;
      k_d      = '0;
      layer_d  = '0;
      raw_d    = '0;
      slices_d = '0;
      prev_d   = 1'b0;
      done_d   = 1'b0;
      err_d    = 1'b0;
      clr      = 1'b1;
      copy_we  = 1'b0;
      shift_we = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MS_IDLE;
      k_q      <= '0;
      layer_q  <= '0;
      raw_q    <= '0;
      slices_q <= '0;
      prev_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      k_q      <= k_d;
      layer_q  <= layer_d;
      raw_q    <= raw_d;
      slices_q <= slices_d;
      prev_q   <= prev_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  assign scan_en      = (mode_q == MS_SCAN);
  assign pattern_done = done_q;
  assign proto_err    = err_q;

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    k_q <= FULL);

  assert_layer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    layer_q <= LAST);

  assert_raw_at_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MS_RAW) |-> (layer_q == LAST));

  assert_scan_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (k_q == FULL));

  assert_scan_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> !scan_en);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pattern_done && !start) |=> (pattern_done && !in_ready));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !start && !abort) |=> ($stable(k_q) && $stable(layer_q)));

endmodule

// File: rtl/mlc_decomp.sv
// Multilayer copy scan test decompressor, top level.
module mlc_decomp #(
  parameter int unsigned NCHAIN     = 8,
  parameter int unsigned NLAYER     = 3,
  parameter int unsigned SPLIT_LOG2 = 1,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CNT_W-1:0]  chain_len,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic [NCHAIN-1:0] slice_out,
  output logic              scan_en,
  output logic              pattern_done,
  output logic              proto_err
);
  localparam int unsigned KW = $clog2(NCHAIN + 1);
  localparam int unsigned LW = (NLAYER > 1) ? $clog2(NLAYER) : 1;

  logic [KW-1:0] fill_nxt;
  logic [LW-1:0] lay_pick;
  logic          clr;
  logic          copy_we;
  logic [LW-1:0] copy_layer;
  logic [KW-1:0] pos;
  logic          shift_we;
  logic          shift_bit;

  mlc_ctrl #(
    .NCHAIN(NCHAIN), .NLAYER(NLAYER), .SPLIT_LOG2(SPLIT_LOG2),
    .CNT_W(CNT_W), .KW(KW), .LW(LW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .chain_len(chain_len), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .fill_nxt(fill_nxt), .lay_pick(lay_pick),
    .clr(clr), .copy_we(copy_we), .copy_layer(copy_layer), .pos(pos),
    .shift_we(shift_we), .shift_bit(shift_bit), .scan_en(scan_en),
    .pattern_done(pattern_done), .proto_err(proto_err)
  );

  mlc_layer_pick #(
    .NCHAIN(NCHAIN), .NLAYER(NLAYER), .SPLIT_LOG2(SPLIT_LOG2),
    .KW(KW), .LW(LW)
  ) u_pick (
    .fill(fill_nxt), .layer(lay_pick)
  );

  mlc_buffer #(
    .NCHAIN(NCHAIN), .NLAYER(NLAYER), .SPLIT_LOG2(SPLIT_LOG2),
    .KW(KW), .LW(LW)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .copy_we(copy_we),
    .copy_layer(copy_layer), .pos(pos), .shift_we(shift_we),
    .shift_bit(shift_bit), .data(slice_out)
  );

  // Chains see no new data while the slice is being shifted out.
  assert_stall_on_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> !in_ready);

  // A slice presented again by a top-layer copy does not change the pins.
  assert_slice_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !start) |=> $stable(slice_out));

endmodule

// File: tb/mlc_decomp_bench.sv
module mlc_decomp_bench;
  localparam int N  = 8;
  localparam int L  = 3;
  localparam int GL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        abort = 1'b0;
  logic [15:0] chain_len = '0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        in_ready;
  logic [N-1:0] slice_out;
  logic        scan_en;
  logic        pattern_done;
  logic        proto_err;

  always #5 clk = ~clk;

  mlc_decomp u_mlc_decomp (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .chain_len(chain_len), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .slice_out(slice_out), .scan_en(scan_en),
    .pattern_done(pattern_done), .proto_err(proto_err)
  );

  int nchk = 0;
  int nerr = 0;
  int ncap = 0;
  int err_seen = 0;
  logic [N-1:0] cap [0:511];
  int strm [0:63];
  int slen = 0;
  int tgt [0:319];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scan monitor: R7 stall rule checked on every slice presentation.
  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_en) begin
        cap[ncap] = slice_out;
        ncap++;
        chk(!in_ready, "R7 ready during scan", int'(in_ready), 0);
      end
      if (proto_err) err_seen++;
    end
  end

  function automatic int derive(input int k);
    for (int l = 0; l < L; l++) if (k % (N >> l) == 0) return l;
    return L - 1;
  endfunction

  task automatic emit(input int b);
    strm[slen] = b;
    slen++;
  endtask

  // Greedy copy-first encoder built from R3..R8.
  task automatic encode(input int t, input int p, input bit hp);
    int k;
    int lay;
    int g;
    bit ok;
    k = 0; lay = 0; slen = 0;
    while (k < N) begin
      g = N >> lay;
      if (k == 0 && lay == 0) ok = hp && (t == p);
      else if (k == 0)        ok = 1'b0;
      else ok = (((t >> k) & ((1 << g) - 1)) == ((t >> (k - g)) & ((1 << g) - 1)));
      if (ok) begin
        emit(1);
        k = (k == 0) ? N : k + g;
        if (k < N) lay = derive(k);
      end else if (lay < L - 1) begin
        emit(0);
        lay++;
      end else begin
        emit(0);
        for (int j = 0; j < GL; j++) emit((t >> (k + j)) & 1);
        k += GL;
        if (k < N) lay = derive(k);
      end
    end
  endtask

  task automatic send_bit(input int b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b[0];
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_stream(input int gap);
    for (int i = 0; i < slen; i++) begin
      send_bit(strm[i]);
      if (gap > 0) begin
        drop();
        repeat (gap) @(negedge clk);
      end
    end
    drop();
  endtask

  task automatic do_start(input int len);
    @(negedge clk);
    chain_len = 16'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!pattern_done) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base;
    int e0;
    int prev;
    int v;
    bit hp;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!in_ready && !scan_en && !pattern_done && !proto_err, "R1 reset controls",
        {in_ready, scan_en, pattern_done, proto_err}, 0);
    chk(slice_out == '0, "R1 reset slice", int'(slice_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Worked stream 0,0,0,(0,1),1,1,1 -> two slices 0xAA
    do_start(2);
    chk(in_ready == 1'b1, "R2 ready after start", int'(in_ready), 1);
    base = ncap;
    send_bit(0);
    drop();
    chk(slice_out == '0 && ncap == base, "R4 advance leaves buffer", int'(slice_out), 0);
    slen = 0;
    emit(0); emit(0); emit(0); emit(1); emit(1); emit(1); emit(1);
    send_stream(0);
    wait_done();
    @(negedge clk);
    chk(ncap - base == 2, "R10 slice count", ncap - base, 2);
    chk(cap[base] == 8'hAA, "R3 R5 R6 first slice", int'(cap[base]), 'hAA);
    chk(cap[base + 1] == 8'hAA, "R8 reused slice", int'(cap[base + 1]), 'hAA);
    chk(pattern_done && !in_ready, "R10 done holds", {pattern_done, in_ready}, 2);

    // R9: illegal copies flagged and ignored
    do_start(1);
    chk(slice_out == '0 && in_ready, "R2 start clears buffer", int'(slice_out), 0);
    base = ncap;
    e0 = err_seen;
    slen = 0;
    emit(1); emit(0); emit(1); emit(0); emit(0); emit(1); emit(1); emit(1); emit(1);
    send_stream(0);
    wait_done();
    @(negedge clk);
    chk(err_seen - e0 == 2, "R9 error pulses", err_seen - e0, 2);
    chk(ncap - base == 1 && cap[base] == 8'hFF, "R9 state untouched", int'(cap[base]), 'hFF);

    // R12: idle gaps on in_valid
    do_start(1);
    base = ncap;
    encode('h3C, 0, 1'b0);
    send_stream(3);
    wait_done();
    @(negedge clk);
    chk(ncap - base == 1 && cap[base] == 8'h3C, "R12 gapped stream", int'(cap[base]), 'h3C);

    // R11: abort mid-pattern
    do_start(5);
    base = ncap;
    slen = 0;
    emit(0); emit(0); emit(0); emit(0); emit(1);
    send_stream(0);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    repeat (3) @(negedge clk);
    chk(!in_ready && !pattern_done, "R11 abort idle", {in_ready, pattern_done}, 0);
    chk(ncap == base, "R11 no slice", ncap - base, 0);

    // Sweep: every 8-bit value, plus repeats exercising top-layer reuse (R3 R5 R6 R8)
    do_start(320);
    base = ncap;
    prev = 0; v = 0; hp = 1'b0;
    for (int s = 0; s < 320; s++) begin
      int t;
      if (s % 5 == 4) t = prev;
      else begin t = v; v++; end
      tgt[s] = t;
      encode(t, prev, hp);
      send_stream(0);
      hp = 1'b1;
      prev = t;
    end
    wait_done();
    @(negedge clk);
    chk(ncap - base == 320, "R10 sweep slice count", ncap - base, 320);
    for (int s = 0; s < 320; s++) begin
      chk(int'(cap[base + s]) == tgt[s], "R3 R6 R8 sweep slice", int'(cap[base + s]), tgt[s]);
    end
    chk(pattern_done && !in_ready, "R10 sweep done", {pattern_done, in_ready}, 2);

    summary();
    $finish;
  end

endmodule